// File: doc/BRIEF.md
# Platform Reset Cause Arbiter

This block collects every reason a platform may need to be reset and turns each into one of five ranked reset classes. Software requests a reset by writing a control byte. The other sources are a reset button, which is synchronised and debounced, a drop in core power-good while the system is running, a thermal trip, a power button held for a long time, a CPU shutdown cycle, and watchdogs on the host-reset and sleep-entry handshakes. Two of these sources decode their class from policy bits that software stored with an earlier write and from a global-reset enable input.

In any cycle, the most severe request wins. One cycle after the request, the block gives a single-cycle result. This result is made of a valid strobe, the class code, a platform-reset strobe, a power-cycle request and a go-to-off request. Downstream power-sequencing logic acts on these strobes.

Top module: `reset_cause_arbiter`

## Requirements
- R1: A control write with bit 2 set starts a reset decoded from the written byte. Bit 3 set gives class 3 (host reset with power cycle). Otherwise, bit 1 set gives class 2 (host reset with platform reset). Otherwise the result is class 1 (host reset, no platform reset), so 0x0E gives 3, 0x06 gives 2 and 0x04 gives 1. A write with bit 2 clear starts nothing but stores bits 1 and 3 as the stored system-select and full-select policy bits.
- R2: When `glb_rst_en` is 1, a triggering write that has bit 1 set (for example 0x06 or 0x0E) gives class 4 (global reset with power cycle).
- R3: A debounced reset-button press gives class 3 if the stored full-select bit is 1. Otherwise it gives class 2 if the stored system-select bit is 1, and class 1 if not. Releasing the button gives nothing.
- R4: The button input passes a two-flop synchroniser and must then stay at a new level for `DB_CYCLES` consecutive clocks before it is accepted. A shorter glitch has no effect.
- R5: A falling edge of `core_pwrok` while `in_working` is 1 gives class 4. The same edge while `in_working` is 0 gives nothing.
- R6: A rising edge of `therm_trip` gives class 5 (go to off state). Holding the input high gives no further events.
- R7: `pwr_btn_n` held low for `PBTN_HOLD_CYCLES` clocks gives class 5 exactly once per hold. A shorter hold gives nothing.
- R8: A `cpu_shutdown` pulse gives class 4 if `glb_rst_en` is 1. Otherwise it gives class 3 if the stored full-select bit is 1, otherwise class 2 if the stored system-select bit is 1, otherwise class 1.
- R9: `host_entry_busy` high for `HOST_TMO_CYCLES` consecutive clocks gives class 4. `sleep_entry_busy` high for `SLEEP_TMO_CYCLES` clocks gives class 5. One clock less gives nothing.
- R10: Requests in the same cycle produce one result, the one with the highest class code.
- R11: The result appears for exactly one cycle, on the clock after the request. In that cycle `rst_valid` is 1 and `rst_class` holds the code. `plt_rst` is 1 for classes 2 to 5, `pwr_cycle_req` is 1 for classes 3 and 4, and `go_off_req` is 1 for class 5 only.
- R12: During and after reset, with no request, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control byte write strobe |
| ctl_wr_data | input | 8 | Control byte |
| glb_rst_en | input | 1 | Policy: promote eligible resets to global |
| rst_btn_n | input | 1 | Raw reset button, active low |
| pwr_btn_n | input | 1 | Power button, active low |
| core_pwrok | input | 1 | Core power-good |
| in_working | input | 1 | System is in a working state |
| therm_trip | input | 1 | Catastrophic thermal trip |
| cpu_shutdown | input | 1 | CPU shutdown cycle pulse |
| host_entry_busy | input | 1 | Host-reset entry handshake pending |
| sleep_entry_busy | input | 1 | Sleep-state entry handshake pending |
| rst_valid | output | 1 | Result strobe |
| rst_class | output | 3 | Winning class code 0..5 |
| plt_rst | output | 1 | Platform reset strobe |
| pwr_cycle_req | output | 1 | Power-cycle request |
| go_off_req | output | 1 | Go-to-off request |

## Verification
The assertions check, on every cycle, the output shape of each class. They also check that a triggering write, a CPU shutdown with global enable, a power-good drop and a thermal edge always produce at least the expected severity on the next clock. In addition, they check that the debounced level changes only towards the synchronised input and that each hold or timeout counter fires once per episode.

Only the bench scenarios can show the rest:
- the exact class for each written byte and each stored policy;
- that glitches, short holds and near-timeouts produce no event;
- that simultaneous requests collapse to the single highest class.

// File: rtl/rca_pkg.sv
package rca_pkg;

  typedef enum logic [2:0] {
    RC_NONE       = 3'd0,
    RC_WARM_QUIET = 3'd1,
    RC_WARM       = 3'd2,
    RC_COLD       = 3'd3,
    RC_GLOBAL     = 3'd4,
    RC_OFF        = 3'd5
  } rcls_e;

  // control byte bit positions (decoded by the classifier)
  localparam int CTL_SYS_BIT  = 1;
  localparam int CTL_GO_BIT   = 2;
  localparam int CTL_FULL_BIT = 3;

  function automatic rcls_e rcls_max(rcls_e a, rcls_e b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rca_debounce.sv
module rca_debounce #(
  parameter int STABLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic press
);
  localparam int CW = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;

  logic [1:0]    sync_q;
  logic          db_q, db_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          commit;

  always_comb begin
    cnt_d  = cnt_q;
    db_d   = db_q;
    commit = 1'b0;
    if (sync_q[1] == db_q) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(STABLE_CYCLES - 1)) begin
      commit = 1'b1;
      db_d   = sync_q[1];
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign press = commit & ~sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      db_q   <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_n};
      db_q   <= db_d;
      cnt_q  <= cnt_d;
    end
  end

  // R4: the filtered level only ever moves to the synchronised input value
  p_db_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (db_q != $past(db_q)) |-> (db_q == $past(sync_q[1])));

endmodule

// File: rtl/rca_timer.sv
module rca_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic fire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    fire  = 1'b0;
    if (!act) begin
      cnt_d = '0;
    end else if (cnt_q != CW'(LIMIT)) begin
      cnt_d = cnt_q + 1'b1;
      fire  = (cnt_q == CW'(LIMIT - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7 / R9: one firing per continuous episode
  p_fire_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

endmodule

// File: rtl/rca_classify.sv
module rca_classify
  import rca_pkg::*;
(
  input  logic  wr_go,
  input  logic  wr_sys,
  input  logic  wr_full,
  input  logic  pol_sys,
  input  logic  pol_full,
  input  logic  glb_en,
  input  logic  btn_press,
  input  logic  shutdown,
  input  logic  pwr_fail,
  input  logic  therm_hit,
  input  logic  pbtn_fire,
  input  logic  host_tmo,
  input  logic  sleep_tmo,
  output rcls_e win
);
  localparam int NSRC = 8;

  rcls_e cand [NSRC];
  rcls_e pol_cls;

  always_comb begin
    pol_cls = pol_full ? RC_COLD : (pol_sys ? RC_WARM : RC_WARM_QUIET);

    cand[0] = RC_NONE;
    if (wr_go) begin
      if (glb_en && wr_sys) cand[0] = RC_GLOBAL;
      else if (wr_full)     cand[0] = RC_COLD;
      else if (wr_sys)      cand[0] = RC_WARM;
      else                  cand[0] = RC_WARM_QUIET;
    end
    cand[1] = btn_press ? pol_cls : RC_NONE;
    cand[2] = shutdown  ? (glb_en ? RC_GLOBAL : pol_cls) : RC_NONE;
    cand[3] = pwr_fail  ? RC_GLOBAL : RC_NONE;
    cand[4] = therm_hit ? RC_OFF    : RC_NONE;
    cand[5] = pbtn_fire ? RC_OFF    : RC_NONE;
    cand[6] = host_tmo  ? RC_GLOBAL : RC_NONE;
    cand[7] = sleep_tmo ? RC_OFF    : RC_NONE;
  end

  // R10: highest code wins
  always_comb begin
    win = RC_NONE;
    for (int i = 0; i < NSRC; i++) win = rcls_max(win, cand[i]);
  end

endmodule

// File: rtl/reset_cause_arbiter.sv
module reset_cause_arbiter
  import rca_pkg::*;
#(
  parameter int DB_CYCLES        = 50000,
  parameter int PBTN_HOLD_CYCLES = 200000000,
  parameter int HOST_TMO_CYCLES  = 1000000,
  parameter int SLEEP_TMO_CYCLES = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr_en,
  input  logic [7:0] ctl_wr_data,
  input  logic       glb_rst_en,
  input  logic       rst_btn_n,
  input  logic       pwr_btn_n,
  input  logic       core_pwrok,
  input  logic       in_working,
  input  logic       therm_trip,
  input  logic       cpu_shutdown,
  input  logic       host_entry_busy,
  input  logic       sleep_entry_busy,
  output logic       rst_valid,
  output logic [2:0] rst_class,
  output logic       plt_rst,
  output logic       pwr_cycle_req,
  output logic       go_off_req
);

  logic  pol_sys_q, pol_full_q, pol_sys_d, pol_full_d;
  logic  pwrok_q, therm_q;
  logic  btn_press, pbtn_fire, host_tmo, sleep_tmo;
  logic  pwr_fail, therm_hit;
  rcls_e win, cls_q;
  logic  valid_q, plt_q, pwr_q, off_q;
  logic  valid_d, plt_d, pwr_d, off_d;
  logic  ctl_unused;

  assign ctl_unused = ^{ctl_wr_data[7:4], ctl_wr_data[0]};

  rca_debounce #(.STABLE_CYCLES(DB_CYCLES)) u_btn_db (
    .clk(clk), .rst_n(rst_n), .raw_n(rst_btn_n), .press(btn_press));

  rca_timer #(.LIMIT(PBTN_HOLD_CYCLES)) u_pbtn_tmr (
    .clk(clk), .rst_n(rst_n), .act(~pwr_btn_n), .fire(pbtn_fire));

  rca_timer #(.LIMIT(HOST_TMO_CYCLES)) u_host_tmr (
    .clk(clk), .rst_n(rst_n), .act(host_entry_busy), .fire(host_tmo));

  rca_timer #(.LIMIT(SLEEP_TMO_CYCLES)) u_sleep_tmr (
    .clk(clk), .rst_n(rst_n), .act(sleep_entry_busy), .fire(sleep_tmo));

  assign pwr_fail  = in_working & pwrok_q & ~core_pwrok;
  assign therm_hit = therm_trip & ~therm_q;

  rca_classify u_cls (
    .wr_go    (ctl_wr_en & ctl_wr_data[CTL_GO_BIT]),
    .wr_sys   (ctl_wr_data[CTL_SYS_BIT]),
    .wr_full  (ctl_wr_data[CTL_FULL_BIT]),
    .pol_sys  (pol_sys_q),
    .pol_full (pol_full_q),
    .glb_en   (glb_rst_en),
    .btn_press(btn_press),
    .shutdown (cpu_shutdown),
    .pwr_fail (pwr_fail),
    .therm_hit(therm_hit),
    .pbtn_fire(pbtn_fire),
    .host_tmo (host_tmo),
    .sleep_tmo(sleep_tmo),
    .win      (win)
  );

  always_comb begin
    pol_sys_d  = pol_sys_q;
    pol_full_d = pol_full_q;
    if (ctl_wr_en) begin
      pol_sys_d  = ctl_wr_data[CTL_SYS_BIT];
      pol_full_d = ctl_wr_data[CTL_FULL_BIT];
    end
    valid_d = (win != RC_NONE);
    plt_d   = (win >= RC_WARM);
    pwr_d   = (win == RC_COLD) || (win == RC_GLOBAL);
    off_d   = (win == RC_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_sys_q  <= 1'b0;
      pol_full_q <= 1'b0;
      pwrok_q    <= 1'b1;
      therm_q    <= 1'b0;
      cls_q      <= RC_NONE;
      valid_q    <= 1'b0;
      plt_q      <= 1'b0;
      pwr_q      <= 1'b0;
      off_q      <= 1'b0;
    end else begin
      pol_sys_q  <= pol_sys_d;
      pol_full_q <= pol_full_d;
      pwrok_q    <= core_pwrok;
      therm_q    <= therm_trip;
      cls_q      <= win;
      valid_q    <= valid_d;
      plt_q      <= plt_d;
      pwr_q      <= pwr_d;
      off_q      <= off_d;
    end
  end

  assign rst_valid     = valid_q;
  assign rst_class     = cls_q;
  assign plt_rst       = plt_q;
  assign pwr_cycle_req = pwr_q;
  assign go_off_req    = off_q;

  p_wr_go_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && ctl_wr_data[CTL_GO_BIT]) |=> rst_valid);

  p_glb_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && ctl_wr_data[CTL_GO_BIT] && ctl_wr_data[CTL_SYS_BIT] && glb_rst_en)
      |=> (rst_class >= 3'd4));

  p_pwrfail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_working && pwrok_q && !core_pwrok) |=> (rst_class >= 3'd4));

  p_therm_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_trip && !therm_q) |=> go_off_req);

  p_shutdown_glb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_shutdown && glb_rst_en) |=> (rst_class >= 3'd4));

  p_off_shape_r11: assert property (@(posedge clk) disable iff (!rst_n)
    go_off_req |-> (plt_rst && !pwr_cycle_req && rst_valid));

  p_pwr_shape_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cycle_req |-> (plt_rst && rst_valid));

endmodule

// File: tb/test_reset_cause_arbiter.sv
`timescale 1ns/1ps
module test_reset_cause_arbiter;

  localparam int DB   = 4;
  localparam int HOLD = 20;
  localparam int HTMO = 10;
  localparam int STMO = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr_en;
  logic [7:0] ctl_wr_data;
  logic       glb_rst_en, rst_btn_n, pwr_btn_n, core_pwrok, in_working;
  logic       therm_trip, cpu_shutdown, host_entry_busy, sleep_entry_busy;
  logic       rst_valid, plt_rst, pwr_cycle_req, go_off_req;
  logic [2:0] rst_class;

  int checks = 0;
  int fails  = 0;
  int ev_cnt = 0;
  logic [2:0] ev_cls;
  logic       ev_plt, ev_pwr, ev_off;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  reset_cause_arbiter #(
    .DB_CYCLES(DB), .PBTN_HOLD_CYCLES(HOLD),
    .HOST_TMO_CYCLES(HTMO), .SLEEP_TMO_CYCLES(STMO)
  ) i_reset_cause_arbiter (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .glb_rst_en(glb_rst_en), .rst_btn_n(rst_btn_n), .pwr_btn_n(pwr_btn_n),
    .core_pwrok(core_pwrok), .in_working(in_working), .therm_trip(therm_trip),
    .cpu_shutdown(cpu_shutdown), .host_entry_busy(host_entry_busy),
    .sleep_entry_busy(sleep_entry_busy), .rst_valid(rst_valid),
    .rst_class(rst_class), .plt_rst(plt_rst), .pwr_cycle_req(pwr_cycle_req),
    .go_off_req(go_off_req));

  // event monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && rst_valid) begin
      ev_cnt = ev_cnt + 1;
      ev_cls = rst_class;
      ev_plt = plt_rst;
      ev_pwr = pwr_cycle_req;
      ev_off = go_off_req;
    end
  end

  // kind: 0 write, 1 shutdown, 2 power fail, 3 thermal, 4 host timeout,
  // 5 sleep timeout, 6 button, 7 power button hold
  // fields: kind[18:15] data[14:7] glb[6] class[5:3] plt[2] pwr[1] off[0]
  localparam int NV = 18;
  localparam logic [18:0] VEC [NV] = '{
    {4'd0, 8'h0E, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0},
    {4'd0, 8'h06, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0},
    {4'd0, 8'h04, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0},
    {4'd0, 8'h06, 1'b1, 3'd4, 1'b1, 1'b1, 1'b0},
    {4'd0, 8'h0E, 1'b1, 3'd4, 1'b1, 1'b1, 1'b0},
    {4'd0, 8'h0C, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0},
    {4'd1, 8'h00, 1'b1, 3'd4, 1'b1, 1'b1, 1'b0},
    {4'd1, 8'h08, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0},
    {4'd1, 8'h02, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0},
    {4'd1, 8'h00, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0},
    {4'd2, 8'h00, 1'b0, 3'd4, 1'b1, 1'b1, 1'b0},
    {4'd3, 8'h00, 1'b0, 3'd5, 1'b1, 1'b0, 1'b1},
    {4'd4, 8'h00, 1'b0, 3'd4, 1'b1, 1'b1, 1'b0},
    {4'd5, 8'h00, 1'b0, 3'd5, 1'b1, 1'b0, 1'b1},
    {4'd6, 8'h08, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0},
    {4'd6, 8'h02, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0},
    {4'd6, 8'h00, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0},
    {4'd7, 8'h00, 1'b0, 3'd5, 1'b1, 1'b0, 1'b1}
  };

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic wr(input logic [7:0] d);
    ctl_wr_en = 1'b1; ctl_wr_data = d; tick(); ctl_wr_en = 1'b0;
  endtask

  function automatic string req_of(input logic [3:0] k, input logic g);
    case (k)
      4'd0: return g ? "R2" : "R1";
      4'd1: return "R8";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4, 4'd5: return "R9";
      4'd6: return "R3";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [3:0] k, input logic [7:0] d);
    case (k)
      4'd0: wr(d);
      4'd1: begin wr(d); tick(); cpu_shutdown = 1'b1; tick(); cpu_shutdown = 1'b0; end
      4'd2: begin core_pwrok = 1'b0; tick(2); core_pwrok = 1'b1; end
      4'd3: begin therm_trip = 1'b1; tick(3); therm_trip = 1'b0; end
      4'd4: begin host_entry_busy = 1'b1; tick(HTMO + 3); host_entry_busy = 1'b0; end
      4'd5: begin sleep_entry_busy = 1'b1; tick(STMO + 3); sleep_entry_busy = 1'b0; end
      4'd6: begin wr(d); tick(); rst_btn_n = 1'b0; tick(DB + 6); rst_btn_n = 1'b1; tick(DB + 6); end
      default: begin pwr_btn_n = 1'b0; tick(HOLD + 3); pwr_btn_n = 1'b1; end
    endcase
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 1'b0; ctl_wr_en = 1'b0; ctl_wr_data = 8'h00; glb_rst_en = 1'b0;
    rst_btn_n = 1'b1; pwr_btn_n = 1'b1; core_pwrok = 1'b1; in_working = 1'b1;
    therm_trip = 1'b0; cpu_shutdown = 1'b0; host_entry_busy = 1'b0; sleep_entry_busy = 1'b0;
    tick(3);
    // R12: outputs quiet in reset
    chk("R12", {rst_valid, rst_class, plt_rst, pwr_cycle_req, go_off_req}, 32'h0);
    rst_n = 1'b1;
    tick(3);
    chk("R12", {ev_cnt[3:0], rst_valid, rst_class, plt_rst, pwr_cycle_req, go_off_req}, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = VEC[i];
      glb_rst_en = v[6];
      tick(2);
      base = ev_cnt;
      apply(v[18:15], v[14:7]);
      tick(6);
      chk(req_of(v[18:15], v[6]),
          {ev_cnt - base, 1'b0, ev_cls, ev_plt, ev_pwr, ev_off},
          {32'd1, 1'b0, v[5:0]} >> 0 == 0 ? 32'h0 : {25'd1, 1'b0, v[5:0]});
      glb_rst_en = 1'b0;
    end

    // R1: no trigger bit, no reset
    base = ev_cnt; wr(8'h0A); tick(4);
    chk("R1 no-trigger", ev_cnt - base, 0);

    // R11: one-cycle pulse one clock after the request
    wr(8'h06);
    chk("R11 valid", {rst_valid, rst_class, plt_rst, pwr_cycle_req, go_off_req}, {1'b1, 3'd2, 3'b100});
    tick();
    chk("R11 single", rst_valid, 0);

    // R4: short glitch ignored
    tick(3); base = ev_cnt;
    rst_btn_n = 1'b0; tick(2); rst_btn_n = 1'b1; tick(DB + 6);
    chk("R4 glitch", ev_cnt - base, 0);

    // R5: power drop outside working state ignored
    base = ev_cnt; in_working = 1'b0;
    core_pwrok = 1'b0; tick(2); core_pwrok = 1'b1; tick(2); in_working = 1'b1; tick(3);
    chk("R5 not working", ev_cnt - base, 0);

    // R7: short hold ignored, very long hold fires once
    base = ev_cnt; pwr_btn_n = 1'b0; tick(HOLD - 2); pwr_btn_n = 1'b1; tick(4);
    chk("R7 short", ev_cnt - base, 0);
    base = ev_cnt; pwr_btn_n = 1'b0; tick(3 * HOLD); pwr_btn_n = 1'b1; tick(4);
    chk("R7 once", ev_cnt - base, 1);

    // R9: timeout boundaries
    base = ev_cnt; host_entry_busy = 1'b1; tick(HTMO - 1); host_entry_busy = 1'b0; tick(4);
    chk("R9 host short", ev_cnt - base, 0);
    base = ev_cnt; host_entry_busy = 1'b1; tick(HTMO); host_entry_busy = 1'b0; tick(4);
    chk("R9 host exact", {ev_cnt - base, 1'b0, ev_cls}, {32'd1, 1'b0, 3'd4});
    base = ev_cnt; sleep_entry_busy = 1'b1; tick(STMO - 1); sleep_entry_busy = 1'b0; tick(4);
    chk("R9 sleep short", ev_cnt - base, 0);

    // R10: simultaneous requests
    base = ev_cnt;
    ctl_wr_en = 1'b1; ctl_wr_data = 8'h06; therm_trip = 1'b1; tick();
    ctl_wr_en = 1'b0; therm_trip = 1'b0; tick(4);
    chk("R10 write+thermal", {ev_cnt - base, 1'b0, ev_cls}, {32'd1, 1'b0, 3'd5});
    base = ev_cnt;
    ctl_wr_en = 1'b1; ctl_wr_data = 8'h04; core_pwrok = 1'b0; tick();
    ctl_wr_en = 1'b0; core_pwrok = 1'b1; tick(4);
    chk("R10 write+powerfail", {ev_cnt - base, 1'b0, ev_cls}, {32'd1, 1'b0, 3'd4});
    wr(8'h00); tick(2); base = ev_cnt;
    ctl_wr_en = 1'b1; ctl_wr_data = 8'h0E; cpu_shutdown = 1'b1; tick();
    ctl_wr_en = 1'b0; cpu_shutdown = 1'b0; tick(4);
    chk("R10 write+shutdown", {ev_cnt - base, 1'b0, ev_cls}, {32'd1, 1'b0, 3'd3});

    done = 1'b1;
    summary();
    $finish;
  end

endmodule